// File: doc/BRIEF.md
# I2C Interrupt Status Aggregator

This block collects the event strobes of an I2C controller and turns them into sticky status flags and a single level-sensitive interrupt request. The bit-count strobes from the serial clock, the address comparator result, the general-call detector, the arbitration monitor and the two bus-timeout detectors all arrive as single-cycle pulses. The block records each one in a flag and raises `irq_o` while any flag is both set and enabled. In low-power mode it also raises `wake_o` for a byte completion or an address hit, provided the wakeup enable is set.

Software reaches the block through a small register port. It can read and write a control register of enable bits, and it can read a status register whose flags it clears by writing ones. The byte-complete flag cannot be cleared by software. Hardware clears it when the next byte transfer begins. Every register port access takes effect in a single cycle, so the port has no handshake. Neither interrupt output accepts back-pressure, because each output is a level and not a stream.

Top module: `i2c_irq_agg`

## Requirements
- R1: During reset and right after it, every status flag, every control bit, `irq_o` and `wake_o` are 0.
- R2: The byte-complete flag (status bit 0) sets on an `scl_fall_i` strobe whose `bit_cnt_i` equals 9 when early-acknowledge (control bit 4) is 0, or equals 8 when early-acknowledge is 1. Strobes carrying any other count leave the flag unchanged.
- R3: The byte-complete flag clears on `xfer_start_i`. Register writes to status bit 0 have no effect on it.
- R4: The addressed flag (status bit 1) sets on `addr_match_i`. It also sets on `gcall_i`, but only when general-call enable (control bit 3) is 1.
- R5: Arbitration-lost (status bit 2), clock-low timeout (status bit 3) and clock-high/data-low timeout (status bit 4) set on their pulses. Status bits 1 to 5 clear only when software writes 1 to that bit at address 1. Writing 0 to any of them leaves it unchanged.
- R6: The pending flag (status bit 5) sets on any set event of byte-complete, addressed, arbitration-lost or clock-low timeout. A clock-high/data-low timeout does not set it.
- R7: `irq_o` is a registered level. It equals global enable (control bit 0) AND (pending OR (clock-high/data-low flag AND its own enable, control bit 1)), and lags the flags by one cycle.
- R8: When a set event and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R9: `wake_o` is a registered level. It equals `lowpower_i` AND global enable AND wakeup enable (control bit 2) AND (byte-complete OR addressed).
- R10: Address 0 is the control register: bits 4:0 are written and read back, and the upper bits read as 0. Address 1 reads the six status flags in bits 5:0. Other addresses read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_fall_i | input | 1 | Serial clock falling-edge strobe |
| bit_cnt_i | input | CNT_W | Index of the clock that just ended (1 to 9) |
| xfer_start_i | input | 1 | A new byte transfer begins |
| addr_match_i | input | 1 | Received address equals the own address |
| gcall_i | input | 1 | General-call address received |
| arb_lost_i | input | 1 | Arbitration lost pulse |
| scl_low_to_i | input | 1 | Clock-low timeout pulse |
| shsl_to_i | input | 1 | Clock-high/data-low timeout pulse |
| lowpower_i | input | 1 | Low-power mode active |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
The hardest case to reach is a flag whose set pulse arrives in the same cycle as a write-1 clear to that same flag. A close second is the wakeup path, which needs low-power mode, two enables and an address or byte event all present together. The directed part of the stimulus creates each of these cases on purpose: a clear and a set in one cycle, a general call with and without its enable, and an early-acknowledge byte at count 8. The random part then mixes in frequent status writes with random data and sparse event pulses, which produces further chance collisions. After each of those cycles, an independent model is compared against the register read, the interrupt output and the wakeup output.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;
  // status flag positions
  localparam int F_TCF  = 0;
  localparam int F_AAS  = 1;
  localparam int F_ARB  = 2;
  localparam int F_SLTO = 3;
  localparam int F_SHSL = 4;
  localparam int F_PEND = 5;
  localparam int NFLAG  = 6;
  // control bit positions
  localparam int C_IE    = 0;
  localparam int C_SHSIE = 1;
  localparam int C_WAKE  = 2;
  localparam int C_GCEN  = 3;
  localparam int C_EACK  = 4;
  localparam int NCTRL   = 5;
  // register addresses
  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;
  // flags software may clear by writing 1
  localparam logic [NFLAG-1:0] W1C_MASK = 6'b111110;
endpackage

// File: rtl/i2c_irq_flag.sv
module i2c_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set has priority over any clear
  always_ff @(posedge clk) begin
    if (!rst_n)      q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/i2c_irq_evt.sv
module i2c_irq_evt
  import i2c_irq_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int BYTE_BITS = 8
) (
  input  logic             scl_fall_i,
  input  logic [CNT_W-1:0] bit_cnt_i,
  input  logic             early_ack_i,
  input  logic             gc_en_i,
  input  logic             addr_match_i,
  input  logic             gcall_i,
  input  logic             arb_lost_i,
  input  logic             scl_low_to_i,
  input  logic             shsl_to_i,
  output logic [NFLAG-1:0] set_o
);
  localparam logic [CNT_W-1:0] ACK_CNT   = CNT_W'(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] EARLY_CNT = CNT_W'(BYTE_BITS);

  logic [CNT_W-1:0] done_cnt;
  logic             tcf_hit, aas_hit;

  assign done_cnt = early_ack_i ? EARLY_CNT : ACK_CNT;
  assign tcf_hit  = scl_fall_i && (bit_cnt_i == done_cnt);
  assign aas_hit  = addr_match_i || (gcall_i && gc_en_i);

  always_comb begin
    set_o         = '0;
    set_o[F_TCF]  = tcf_hit;
    set_o[F_AAS]  = aas_hit;
    set_o[F_ARB]  = arb_lost_i;
    set_o[F_SLTO] = scl_low_to_i;
    set_o[F_SHSL] = shsl_to_i;
    set_o[F_PEND] = tcf_hit | aas_hit | arb_lost_i | scl_low_to_i;
  end
endmodule

// File: rtl/i2c_irq_regs.sv
module i2c_irq_regs
  import i2c_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NFLAG-1:0]  flag_i,
  output logic [NCTRL-1:0]  ctrl_o,
  output logic [NFLAG-1:0]  swclr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic sel_ctrl, sel_stat;
  logic unused_wdata;

  assign sel_ctrl     = (addr_i == A_CTRL);
  assign sel_stat     = (addr_i == A_STAT);
  assign unused_wdata = ^wdata_i[DATA_W-1:NFLAG];

  always_ff @(posedge clk) begin
    if (!rst_n)                ctrl_o <= '0;
    else if (wr_i && sel_ctrl) ctrl_o <= wdata_i[NCTRL-1:0];
  end

  assign swclr_o = (wr_i && sel_stat) ? (wdata_i[NFLAG-1:0] & W1C_MASK) : '0;

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)      rdata_o[NCTRL-1:0] = ctrl_o;
    else if (sel_stat) rdata_o[NFLAG-1:0] = flag_i;
  end
endmodule

// File: rtl/i2c_irq_agg.sv
module i2c_irq_agg
  import i2c_irq_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int BYTE_BITS = 8,
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_fall_i,
  input  logic [CNT_W-1:0]  bit_cnt_i,
  input  logic              xfer_start_i,
  input  logic              addr_match_i,
  input  logic              gcall_i,
  input  logic              arb_lost_i,
  input  logic              scl_low_to_i,
  input  logic              shsl_to_i,
  input  logic              lowpower_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [NFLAG-1:0] set_vec, swclr, hwclr, flag_q;
  logic [NCTRL-1:0] ctrl_q;

  i2c_irq_evt #(.CNT_W(CNT_W), .BYTE_BITS(BYTE_BITS)) evt_i (
    .scl_fall_i   (scl_fall_i),
    .bit_cnt_i    (bit_cnt_i),
    .early_ack_i  (ctrl_q[C_EACK]),
    .gc_en_i      (ctrl_q[C_GCEN]),
    .addr_match_i (addr_match_i),
    .gcall_i      (gcall_i),
    .arb_lost_i   (arb_lost_i),
    .scl_low_to_i (scl_low_to_i),
    .shsl_to_i    (shsl_to_i),
    .set_o        (set_vec)
  );

  i2c_irq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .flag_i  (flag_q),
    .ctrl_o  (ctrl_q),
    .swclr_o (swclr),
    .rdata_o (reg_rdata_o)
  );

  // byte-complete is the only flag hardware clears
  always_comb begin
    hwclr        = '0;
    hwclr[F_TCF] = xfer_start_i;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    i2c_irq_flag flag_i (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (set_vec[g]),
      .clr_i (swclr[g] | hwclr[g]),
      .q_o   (flag_q[g])
    );
  end

  logic irq_d, wake_d;
  assign irq_d  = ctrl_q[C_IE] &
                  (flag_q[F_PEND] | (flag_q[F_SHSL] & ctrl_q[C_SHSIE]));
  assign wake_d = lowpower_i & ctrl_q[C_IE] & ctrl_q[C_WAKE] &
                  (flag_q[F_TCF] | flag_q[F_AAS]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= irq_d;
      wake_o <= wake_d;
    end
  end
endmodule

// File: rtl/i2c_irq_chk.sv
module i2c_irq_chk
  import i2c_irq_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int BYTE_BITS = 8,
  parameter int ADDR_W    = 2,
  parameter int DATA_W    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_fall_i,
  input logic [CNT_W-1:0]  bit_cnt_i,
  input logic              xfer_start_i,
  input logic              addr_match_i,
  input logic              gcall_i,
  input logic              arb_lost_i,
  input logic              lowpower_i,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [NFLAG-1:0]  flag_q,
  input logic [NCTRL-1:0]  ctrl_q,
  input logic              irq_o,
  input logic              wake_o
);
  logic [CNT_W-1:0] want_cnt;
  logic             byte_hit, slto_wclr;
  assign want_cnt  = ctrl_q[C_EACK] ? CNT_W'(BYTE_BITS) : CNT_W'(BYTE_BITS + 1);
  assign byte_hit  = scl_fall_i && (bit_cnt_i == want_cnt);
  assign slto_wclr = reg_wr_i && (reg_addr_i == ADDR_W'(STAT_ADDR)) && reg_wdata_i[F_SLTO];

  a_r2_byte_sets: assert property (@(posedge clk) disable iff (!rst_n)
    byte_hit |=> flag_q[F_TCF]);
  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start_i && !byte_hit) |=> !flag_q[F_TCF]);
  a_r4_gc_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_match_i && !(gcall_i && ctrl_q[C_GCEN]) && !flag_q[F_AAS]) |=> !flag_q[F_AAS]);
  a_r5_slto_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[F_SLTO] && !slto_wclr) |=> flag_q[F_SLTO]);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost_i |=> flag_q[F_ARB]);
  a_r7_irq_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[C_IE] |=> !irq_o);
  a_r7_irq_on: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[C_IE] && flag_q[F_PEND]) |=> irq_o);
  a_r9_wake_off: assert property (@(posedge clk) disable iff (!rst_n)
    !lowpower_i |=> !wake_o);
endmodule

bind i2c_irq_agg i2c_irq_chk #(
  .CNT_W(CNT_W), .BYTE_BITS(BYTE_BITS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .scl_fall_i   (scl_fall_i),
  .bit_cnt_i    (bit_cnt_i),
  .xfer_start_i (xfer_start_i),
  .addr_match_i (addr_match_i),
  .gcall_i      (gcall_i),
  .arb_lost_i   (arb_lost_i),
  .lowpower_i   (lowpower_i),
  .reg_wr_i     (reg_wr_i),
  .reg_addr_i   (reg_addr_i),
  .reg_wdata_i  (reg_wdata_i),
  .flag_q       (flag_q),
  .ctrl_q       (ctrl_q),
  .irq_o        (irq_o),
  .wake_o       (wake_o)
);

// File: tb/i2c_irq_agg_tb.sv
module i2c_irq_agg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_fall, xfer_start, addr_match, gcall, arb_lost, slto, shsl, lowpower, reg_wr;
  logic [3:0] bit_cnt;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq, wake;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .scl_fall_i(scl_fall), .bit_cnt_i(bit_cnt),
    .xfer_start_i(xfer_start), .addr_match_i(addr_match), .gcall_i(gcall),
    .arb_lost_i(arb_lost), .scl_low_to_i(slto), .shsl_to_i(shsl),
    .lowpower_i(lowpower), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq), .wake_o(wake)
  );

  int   n_chk = 0, n_err = 0;
  bit   done = 0;
  logic [5:0] m_flag, n_flag;
  logic [4:0] m_ctrl, n_ctrl;
  logic       m_irq, n_irq, m_wake, n_wake;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] a);
    if (a == 2'd0) return {3'b0, m_ctrl};
    if (a == 2'd1) return {2'b0, m_flag};
    return 8'h00;
  endfunction

  // compare all observable outputs against the model
  task automatic check_all();
    logic [5:0] f;
    chk("R7 irq", {7'b0, irq}, {7'b0, m_irq});
    chk("R9 wake", {7'b0, wake}, {7'b0, m_wake});
    if (reg_addr == 2'd1) begin
      f = reg_rdata[5:0];
      chk("R2 R3 byte-complete", {7'b0, f[0]}, {7'b0, m_flag[0]});
      chk("R4 addressed", {7'b0, f[1]}, {7'b0, m_flag[1]});
      chk("R5 R8 timeout/arb flags", {5'b0, f[4:2]}, {5'b0, m_flag[4:2]});
      chk("R6 pending", {7'b0, f[5]}, {7'b0, m_flag[5]});
      chk("R10 status upper", {6'b0, reg_rdata[7:6]}, 8'h00);
    end else begin
      chk("R10 read", reg_rdata, exp_read(reg_addr));
    end
  endtask

  // drive one cycle of inputs, advance model, check after the edge
  task automatic cyc(input logic sf, input logic [3:0] bc, input logic xs,
                     input logic am, input logic gc, input logic al,
                     input logic lt, input logic ht, input logic lp,
                     input logic wr, input logic [1:0] ad, input logic [7:0] wd);
    logic tcf_e, aas_e;
    logic [5:0] set_v, clr_v;
    scl_fall = sf; bit_cnt = bc; xfer_start = xs; addr_match = am; gcall = gc;
    arb_lost = al; slto = lt; shsl = ht; lowpower = lp;
    reg_wr = wr; reg_addr = ad; reg_wdata = wd;
    n_irq  = m_ctrl[0] & (m_flag[5] | (m_flag[4] & m_ctrl[1]));
    n_wake = lp & m_ctrl[0] & m_ctrl[2] & (m_flag[0] | m_flag[1]);
    tcf_e  = sf && (bc == (m_ctrl[4] ? 4'd8 : 4'd9));
    aas_e  = am | (gc & m_ctrl[3]);
    set_v  = {tcf_e | aas_e | al | lt, ht, lt, al, aas_e, tcf_e};
    clr_v  = (wr && ad == 2'd1) ? (wd[5:0] & 6'b111110) : 6'b0;
    clr_v[0] = xs;
    n_flag = set_v | (m_flag & ~clr_v);
    n_ctrl = (wr && ad == 2'd0) ? wd[4:0] : m_ctrl;
    @(negedge clk);
    m_flag = n_flag; m_ctrl = n_ctrl; m_irq = n_irq; m_wake = n_wake;
    check_all();
  endtask

  task automatic idle(input logic [1:0] ad);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, ad, 0);
  endtask

  task automatic wreg(input logic [1:0] ad, input logic [7:0] wd);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, ad, wd);
  endtask

  initial begin
    rst_n = 0;
    {scl_fall, xfer_start, addr_match, gcall, arb_lost, slto, shsl, lowpower, reg_wr} = '0;
    bit_cnt = 0; reg_addr = 0; reg_wdata = 0;
    m_flag = 0; m_ctrl = 0; m_irq = 0; m_wake = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 wake", {7'b0, wake}, 8'h00);
    chk("R1 ctrl", reg_rdata, 8'h00);
    reg_addr = 2'd1; #1;
    chk("R1 status", reg_rdata, 8'h00);
    @(negedge clk);
    rst_n = 1;
    idle(1);

    // R2: normal mode sets on 9, not 8
    wreg(0, 8'h01);
    cyc(1, 4'd8, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R2 count 8 ignored", reg_rdata, 8'h00);
    cyc(1, 4'd9, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R2 count 9 sets", reg_rdata, 8'h21);
    idle(1);
    chk("R7 irq raised", {7'b0, irq}, 8'h01);
    // R3: write 1 to byte-complete has no effect, start clears it
    wreg(1, 8'h01);
    chk("R3 write ignored", reg_rdata, 8'h21);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R3 start clears", reg_rdata, 8'h20);
    wreg(1, 8'h20);
    idle(1);
    chk("R7 irq drops", {7'b0, irq}, 8'h00);
    // R2: early acknowledge
    wreg(0, 8'h11);
    cyc(1, 4'd9, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R2 early count 9 ignored", reg_rdata, 8'h00);
    cyc(1, 4'd8, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R2 early count 8 sets", reg_rdata, 8'h21);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 1, 8'h20);
    // R4: general call gating
    wreg(0, 8'h01);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0);
    chk("R4 gcall blocked", reg_rdata, 8'h00);
    wreg(0, 8'h09);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 1, 0);
    chk("R4 gcall accepted", reg_rdata, 8'h22);
    // R9: wakeup in low power
    wreg(0, 8'h05);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, 0);
    chk("R9 wake asserted", {7'b0, wake}, 8'h01);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 8'h22);
    chk("R9 wake off outside low power", {7'b0, wake}, 8'h00);
    // R5: clock-low timeout sticky, write 0 no effect
    cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 0);
    wreg(1, 8'h00);
    chk("R5 write 0 keeps", reg_rdata, 8'h28);
    wreg(1, 8'h28);
    chk("R5 write 1 clears", reg_rdata, 8'h00);
    // R8: set and clear same cycle
    cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 1, 1, 8'h3E);
    chk("R8 set wins", reg_rdata, 8'h24);
    wreg(1, 8'h24);
    // R6 R7: clock-high/data-low timeout needs its own enable
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0);
    chk("R6 no pending", reg_rdata, 8'h10);
    idle(1);
    chk("R7 irq needs own enable", {7'b0, irq}, 8'h00);
    wreg(0, 8'h03);
    idle(1);
    chk("R7 irq with own enable", {7'b0, irq}, 8'h01);
    // R10: other addresses
    wreg(2, 8'hFF);
    wreg(3, 8'hFF);
    idle(0);
    chk("R10 ctrl unchanged", reg_rdata, 8'h03);

    // random phase
    void'($urandom(32'd1357));
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], 4'($urandom_range(1, 9)), (r[4:1] == 0), (r[8:5] == 0),
          (r[11:9] == 0), (r[15:12] == 0), (r[19:16] == 0), (r[23:20] == 0),
          r[24], (r[27:25] < 2), r[29:28], 8'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule